// File: doc/BRIEF.md
# Level-1 Accept Event Filter

This block sits in a front-end readout path and forwards only the hit records that belong to beam crossings the Level-1 trigger accepted. It keeps a free-running crossing counter, wider than the native crossing tag, and derives from it a lagged crossing number. The lag equals the trigger latency, given in crossings. When an accept pulse arrives, the lagged crossing is taken as the crossing that was accepted. That crossing number is pushed into a small queue together with a running event number.

Hit records arrive in time order on a valid/ready stream. Each record carries its crossing number and a payload. Every record is compared with the oldest pending accepted crossing, and the window half-width sets how far a record may sit from it:

- A record inside the window is forwarded with that event's number attached.
- A record older than the window is thrown away.
- A record newer than the window retires the pending crossing, and is then compared with the next one.

All comparisons use the wrapped signed difference of crossing numbers. A counter rollover therefore does not disturb the ordering.

Top module: `l1_accept_filter`

## Requirements
- R1: `xing_now` is a CNT_W-bit (default 12) counter. It is 0 after reset, advances by one on each cycle with `xing_tick` high, and wraps from 2^CNT_W-1 to 0.
- R2: `xing_lag` equals `xing_now - latency` modulo 2^CNT_W. `latency` takes any value from 0 to 63.
- R3: Each `l1_accept` pulse queues the current `xing_lag` together with an event number. Event numbers start at 0 after reset and increase by one per accept.
- R4: An accepted record leaves on `out_*` on the cycle after its input handshake, with `out_event` equal to the head entry's event number. A record is accepted when its crossing minus the head crossing, as a signed value, lies in [-window, +window].
- R5: A record whose signed difference from the head crossing is below -window is consumed and produces no output.
- R6: A record whose signed difference is above +window is not consumed and removes the head entry. The record is then compared with the next entry on the following cycle.
- R7: With the queue empty, a record whose signed difference from `xing_lag` is below -window is discarded. Any other record is held with `in_ready` low.
- R8: Crossing differences are computed modulo 2^CNT_W and read as signed. A record at crossing 0 therefore matches a queued crossing 2^CNT_W-1 with window 1.
- R9: While `out_valid` is high and `out_ready` is low, `out_data`, `out_xing` and `out_event` stay constant. During that time `in_ready` is low for records that would be forwarded.
- R10: An accept that arrives while 16 entries are pending is not queued, and it sets `q_overflow`. `q_overflow` stays high until reset.
- R11: After reset the queue is empty, and `out_valid` and `q_overflow` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| xing_tick | input | 1 | One pulse per beam crossing |
| latency | input | LAT_W | Trigger latency in crossings |
| window | input | WIN_W | Half-width of the match window in crossings |
| l1_accept | input | 1 | Level-1 accept pulse |
| in_valid | input | 1 | Input record valid |
| in_ready | output | 1 | Input record taken this cycle |
| in_xing | input | CNT_W | Crossing number of the input record |
| in_data | input | PAY_W | Input record payload |
| out_valid | output | 1 | Output record valid |
| out_ready | input | 1 | Downstream can take the output record |
| out_xing | output | CNT_W | Crossing number of the output record |
| out_data | output | PAY_W | Output record payload |
| out_event | output | EVT_W | Event number of the matched accept |
| xing_now | output | CNT_W | Current crossing count |
| xing_lag | output | CNT_W | Crossing count minus latency |
| q_overflow | output | 1 | Sticky accept-queue overflow flag |

## Verification
The bench covers several corner cases, and each one catches a specific kind of wrong design:

- **Window edges at ±1.** A design with off-by-one window edges drops the edge records or forwards their neighbours.
- **A record that retires one accepted crossing and is then dropped against the next.** A design that consumes the record when it pops the head sends it out with the wrong event number.
- **An accepted crossing that sits at the counter rollover.** An unsigned compare throws away the record tagged 0.
- **Output backpressure, an empty queue, and a seventeenth accept.** A wrong design overwrites a held output, stalls forever on stale records, or corrupts the oldest pending entry.

// File: rtl/l1f_pkg.sv
package l1f_pkg;
  typedef enum logic [1:0] {
    ACT_HOLD = 2'd0,
    ACT_DROP = 2'd1,
    ACT_PASS = 2'd2,
    ACT_POP  = 2'd3
  } l1f_act_e;
endpackage

// File: rtl/l1f_xing_counter.sv
module l1f_xing_counter #(
  parameter int CNT_W = 12,
  parameter int LAT_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic [LAT_W-1:0] latency,
  output logic [CNT_W-1:0] xing_now,
  output logic [CNT_W-1:0] xing_lag
);
  always_ff @(posedge clk) begin
    if (rst) xing_now <= '0;
    else if (tick) xing_now <= xing_now + 1'b1;
  end

  // lagged count follows the live count and the latency setting at once
  assign xing_lag = xing_now - CNT_W'(latency);

  AST_XING_STEP: assert property (@(posedge clk) disable iff (rst)
    tick |=> xing_now == $past(xing_now) + 1'b1); // R1
  AST_XING_IDLE: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(xing_now)); // R1
endmodule

// File: rtl/l1f_accept_fifo.sv
module l1f_accept_fifo #(
  parameter int X_W   = 12,
  parameter int E_W   = 16,
  parameter int DEPTH = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           push,
  input  logic [X_W-1:0] push_xing,
  input  logic [E_W-1:0] push_evt,
  input  logic           pop,
  output logic [X_W-1:0] head_xing,
  output logic [E_W-1:0] head_evt,
  output logic           empty,
  output logic           full
);
  localparam int AW = $clog2(DEPTH);
  localparam int EW = X_W + E_W;

  logic [EW-1:0] mem [DEPTH];
  logic [AW:0]   wr_p, rd_p;

  assign empty = (wr_p == rd_p);
  assign full  = (wr_p[AW] != rd_p[AW]) && (wr_p[AW-1:0] == rd_p[AW-1:0]);

  // storage kept free of reset so it maps onto RAM
  always_ff @(posedge clk) begin
    if (push) mem[wr_p[AW-1:0]] <= {push_xing, push_evt};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_p <= '0;
      rd_p <= '0;
    end else begin
      if (push) wr_p <= wr_p + 1'b1;
      if (pop)  rd_p <= rd_p + 1'b1;
    end
  end

  assign {head_xing, head_evt} = mem[rd_p[AW-1:0]];

  AST_NO_POP_EMPTY: assert property (@(posedge clk) disable iff (rst)
    pop |-> !empty); // R6
  AST_NO_PUSH_FULL: assert property (@(posedge clk) disable iff (rst)
    push |-> !full); // R10
endmodule

// File: rtl/l1f_match.sv
module l1f_match
  import l1f_pkg::*;
#(
  parameter int CNT_W = 12,
  parameter int WIN_W = 4
) (
  input  logic             rec_valid,
  input  logic [CNT_W-1:0] rec_xing,
  input  logic             head_valid,
  input  logic [CNT_W-1:0] head_xing,
  input  logic [CNT_W-1:0] lag_xing,
  input  logic [WIN_W-1:0] window,
  input  logic             out_free,
  output l1f_act_e         act
);
  logic [CNT_W-1:0]      ref_x, diff;
  logic signed [CNT_W:0] dx, wx;
  logic                  older, newer;

  always_comb begin
    // with nothing pending, the lagged count bounds every future accept
    ref_x = head_valid ? head_xing : lag_xing;
    diff  = rec_xing - ref_x;
    dx    = $signed({diff[CNT_W-1], diff});
    wx    = $signed({{(CNT_W+1-WIN_W){1'b0}}, window});
    older = dx < -wx;
    newer = dx > wx;
    if (!rec_valid)      act = ACT_HOLD;
    else if (older)      act = ACT_DROP;
    else if (!head_valid) act = ACT_HOLD;
    else if (newer)      act = ACT_POP;
    else if (out_free)   act = ACT_PASS;
    else                 act = ACT_HOLD;
  end
endmodule

// File: rtl/l1_accept_filter.sv
module l1_accept_filter
  import l1f_pkg::*;
#(
  parameter int CNT_W   = 12,
  parameter int LAT_W   = 6,
  parameter int WIN_W   = 4,
  parameter int EVT_W   = 16,
  parameter int PAY_W   = 16,
  parameter int Q_DEPTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             xing_tick,
  input  logic [LAT_W-1:0] latency,
  input  logic [WIN_W-1:0] window,
  input  logic             l1_accept,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [CNT_W-1:0] in_xing,
  input  logic [PAY_W-1:0] in_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [CNT_W-1:0] out_xing,
  output logic [PAY_W-1:0] out_data,
  output logic [EVT_W-1:0] out_event,
  output logic [CNT_W-1:0] xing_now,
  output logic [CNT_W-1:0] xing_lag,
  output logic             q_overflow
);
  logic [EVT_W-1:0] evt_cnt;
  logic             q_empty, q_full, q_push, q_pop, out_free;
  logic [CNT_W-1:0] head_x;
  logic [EVT_W-1:0] head_e;
  l1f_act_e         act;

  l1f_xing_counter #(.CNT_W(CNT_W), .LAT_W(LAT_W)) u_cnt (
    .clk(clk), .rst(rst), .tick(xing_tick), .latency(latency),
    .xing_now(xing_now), .xing_lag(xing_lag)
  );

  assign q_push = l1_accept && !q_full;

  always_ff @(posedge clk) begin
    if (rst) begin
      evt_cnt    <= '0;
      q_overflow <= 1'b0;
    end else begin
      if (l1_accept) evt_cnt <= evt_cnt + 1'b1;
      if (l1_accept && q_full) q_overflow <= 1'b1;
    end
  end

  l1f_accept_fifo #(.X_W(CNT_W), .E_W(EVT_W), .DEPTH(Q_DEPTH)) u_q (
    .clk(clk), .rst(rst), .push(q_push), .push_xing(xing_lag),
    .push_evt(evt_cnt), .pop(q_pop), .head_xing(head_x),
    .head_evt(head_e), .empty(q_empty), .full(q_full)
  );

  assign out_free = !out_valid || out_ready;

  l1f_match #(.CNT_W(CNT_W), .WIN_W(WIN_W)) u_match (
    .rec_valid(in_valid), .rec_xing(in_xing), .head_valid(!q_empty),
    .head_xing(head_x), .lag_xing(xing_lag), .window(window),
    .out_free(out_free), .act(act)
  );

  assign in_ready = (act == ACT_DROP) || (act == ACT_PASS);
  assign q_pop    = (act == ACT_POP);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_xing  <= '0;
      out_data  <= '0;
      out_event <= '0;
    end else begin
      if (out_valid && out_ready) out_valid <= 1'b0;
      if (act == ACT_PASS) begin
        out_valid <= 1'b1;
        out_xing  <= in_xing;
        out_data  <= in_data;
        out_event <= head_e;
      end
    end
  end

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_event) && $stable(out_xing)); // R9
  AST_EVT_STEP: assert property (@(posedge clk) disable iff (rst)
    l1_accept |=> evt_cnt == $past(evt_cnt) + 1'b1); // R3
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (rst)
    q_overflow |=> q_overflow); // R10
  AST_PASS_NEEDS_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    $rose(out_valid) |-> $past(!q_empty)); // R4
  AST_DROP_NO_OUTPUT: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready && !out_valid |=> out_valid == !$past(act == ACT_DROP)); // R5
endmodule

// File: tb/test_l1_accept_filter.sv
module test_l1_accept_filter;
  logic        clk = 0;
  logic        rst = 1;
  logic        xing_tick = 0;
  logic [5:0]  latency = 6'd12;
  logic [3:0]  window = 4'd1;
  logic        l1_accept = 0;
  logic        in_valid = 0;
  logic        in_ready;
  logic [11:0] in_xing = '0;
  logic [15:0] in_data = '0;
  logic        out_valid;
  logic        out_ready = 1;
  logic [11:0] out_xing;
  logic [15:0] out_data;
  logic [15:0] out_event;
  logic [11:0] xing_now, xing_lag;
  logic        q_overflow;

  int n_chk = 0;
  int n_fail = 0;
  int n_got = 0;
  logic [15:0] got_d [64];
  int          got_e [64];

  always #2 clk = ~clk;

  l1_accept_filter i_l1_accept_filter (
    .clk(clk), .rst(rst), .xing_tick(xing_tick), .latency(latency),
    .window(window), .l1_accept(l1_accept), .in_valid(in_valid),
    .in_ready(in_ready), .in_xing(in_xing), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_xing(out_xing),
    .out_data(out_data), .out_event(out_event), .xing_now(xing_now),
    .xing_lag(xing_lag), .q_overflow(q_overflow)
  );

  // stimulus table: crossing tag, expect forwarded, expected event
  localparam int NV = 9;
  localparam int VX [NV] = '{5, 7, 8, 9, 10, 12, 14, 15, 23};
  localparam int VP [NV] = '{0, 1, 1, 1, 0, 1, 1, 0, 1};
  localparam int VE [NV] = '{0, 0, 0, 0, 0, 1, 1, 0, 2};

  always @(negedge clk) begin
    if (!rst && out_valid && out_ready && n_got < 64) begin
      got_d[n_got] = out_data;
      got_e[n_got] = int'(out_event);
      n_got++;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1;
    repeat (3) @(posedge clk);
    #1 rst = 0;
  endtask

  task automatic tick(input int n);
    xing_tick = 1;
    repeat (n) @(posedge clk);
    #1 xing_tick = 0;
  endtask

  task automatic accept();
    l1_accept = 1;
    @(posedge clk);
    #1 l1_accept = 0;
  endtask

  task automatic send(input int x, input int d, input string req);
    int n = 0;
    bit rdy = 0;
    in_valid = 1;
    in_xing = x[11:0];
    in_data = d[15:0];
    do begin
      @(negedge clk);
      rdy = in_ready;
      @(posedge clk);
      #1;
      n++;
    end while (!rdy && n < 50);
    in_valid = 0;
    if (!rdy) chk(0, req, 0, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int base;
    int k;
    do_reset();
    @(negedge clk);
    // R11 reset state
    chk(xing_now == 0, "R11 count", int'(xing_now), 0);
    chk(out_valid == 0, "R11 out_valid", int'(out_valid), 0);
    chk(q_overflow == 0, "R11 overflow", int'(q_overflow), 0);
    chk(in_ready == 0, "R11 in_ready", int'(in_ready), 0);

    @(posedge clk); #1;
    tick(20);
    @(negedge clk);
    chk(xing_now == 20, "R1 count", int'(xing_now), 20);
    chk(xing_lag == 8, "R2 lag 12", int'(xing_lag), 8);
    @(posedge clk); #1 latency = 6'd40;
    @(negedge clk);
    chk(xing_lag == 4076, "R2 lag 40", int'(xing_lag), 4076);
    @(posedge clk); #1 latency = 6'd12;

    // R3 three accepts at lagged crossings 8, 13, 23
    accept();
    tick(5);
    accept();
    tick(10);
    accept();

    // table walk: R4 pass, R5 drop, R6 pop then re-compare
    for (int i = 0; i < NV; i++) send(VX[i], 100 + i, "R4/R5/R6 table");
    repeat (3) @(negedge clk);
    chk(n_got == 6, "R5 output count", n_got, 6);
    k = 0;
    for (int i = 0; i < NV; i++) begin
      if (VP[i] != 0) begin
        chk(got_d[k] == 16'(100 + i) && got_e[k] == VE[i], "R4 record/event",
            got_e[k] * 1000 + int'(got_d[k]), VE[i] * 1000 + 100 + i);
        k++;
      end
    end

    // R7 empty queue: newer record held, older record discarded
    @(posedge clk); #1;
    in_valid = 1; in_xing = 12'd30; in_data = 16'h0777;
    repeat (4) @(negedge clk);
    chk(in_ready == 0, "R7 hold", int'(in_ready), 0);
    @(posedge clk); #1 in_xing = 12'd20;
    @(negedge clk);
    chk(in_ready == 1, "R7 discard ready", int'(in_ready), 1);
    @(posedge clk); #1 in_valid = 0;
    repeat (3) @(negedge clk);
    chk(n_got == 6, "R7 no output", n_got, 6);

    // R9 backpressure
    @(posedge clk); #1;
    accept();
    out_ready = 0;
    send(23, 16'hA1, "R9 first");
    in_valid = 1; in_xing = 12'd23; in_data = 16'hB2;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(out_valid && out_data == 16'hA1 && in_ready == 0, "R9 hold",
          int'(out_data), 16'hA1);
    end
    @(posedge clk); #1 out_ready = 1;
    @(posedge clk); #1 in_valid = 0;
    repeat (3) @(negedge clk);
    chk(n_got == 8 && got_d[6] == 16'hA1 && got_e[6] == 3, "R9 first out",
        int'(got_d[6]), 16'hA1);
    chk(got_d[7] == 16'hB2 && got_e[7] == 3, "R9 second out", int'(got_d[7]), 16'hB2);

    // R8 wraparound: accepted crossing 4095, record 0 within window
    do_reset();
    tick(11);
    @(negedge clk);
    chk(xing_lag == 4095, "R2 lag wrap", int'(xing_lag), 4095);
    @(posedge clk); #1;
    accept();
    base = n_got;
    send(4094, 16'hC1, "R8 first");
    send(0, 16'hC2, "R8 second");
    repeat (3) @(negedge clk);
    chk(n_got == base + 2, "R8 count", n_got - base, 2);
    chk(got_d[base] == 16'hC1 && got_e[base] == 0, "R8 before wrap", int'(got_d[base]), 16'hC1);
    chk(got_d[base+1] == 16'hC2 && got_e[base+1] == 0, "R8 after wrap", int'(got_d[base+1]), 16'hC2);

    // R10 overflow
    do_reset();
    tick(20);
    for (int i = 0; i < 16; i++) accept();
    @(negedge clk);
    chk(q_overflow == 0, "R10 full no flag", int'(q_overflow), 0);
    @(posedge clk); #1;
    accept();
    repeat (3) @(negedge clk);
    chk(q_overflow == 1, "R10 flag sticky", int'(q_overflow), 1);
    @(posedge clk); #1;
    base = n_got;
    send(8, 16'hD1, "R10 head");
    repeat (2) @(negedge clk);
    chk(n_got == base + 1 && got_e[base] == 0, "R10 head intact", got_e[base], 0);

    do_reset();
    @(negedge clk);
    chk(q_overflow == 0 && out_valid == 0, "R11 clear", int'(q_overflow), 0);

    // R1 counter rollover
    @(posedge clk); #1;
    tick(4096);
    @(negedge clk);
    chk(xing_now == 0, "R1 wrap", int'(xing_now), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule